// File: doc/BRIEF.md
# Timer Port Pin Multiplexer

This block sits between an eight-pin timer port and the logic that uses it. Each pin plays one of three roles: a plain input, a general-purpose output driven from a port data latch, or an output owned by the output-compare unit. The port data latch can be written from the bus at any time. The bus readback returns the live pin level for inputs and the latch contents for any pin that is driven.

Every pin level also passes through a two-stage synchronizer. Its output feeds the input-capture logic. Pin 7 is shared with a pulse-accumulator input. The accumulator is given that pin only when all three channel-7 timer controls are clear: both action-select bits and the channel-7 mask bit.

The block also carries the channel-7 counter-reset request through unchanged, whatever role pin 7 has. The compare, capture and accumulator counters themselves are outside this block. Only their enables and levels appear at its ports.

Top module: `tmr_port_mux`

## Requirements
- R1: While reset is applied and after it ends, the port data latch holds all zeros. A driven pin reads back 0 until the first write, and every synchronized capture output is 0.
- R2: A cycle with `bus_wr_i` high stores `bus_wdata_i` into the latch at that clock edge. From the next cycle on, every pin with `dir_i` = 1 or an active timer role reads back the stored bit.
- R3: A pin with `dir_i` = 0 and no active timer role reads back its present `pin_i` level on `bus_rdata_o`, with no delay.
- R4: A pin with `dir_i` = 1 and no active timer role has `pin_oe_o` = 1, and `pin_o` equals its latch bit.
- R5: A pin whose timer role is active has `pin_oe_o` = 1 and `pin_o` = `oc_pin_lvl_i` for that pin, whatever `dir_i` is. Bus writes still update its latch bit, and that latch bit is what reads back.
- R6: The timer role of pin n is active when `oc_sel0_i[n]` or `oc_sel1_i[n]` is 1. For pin 7 only, it is also active when `oc7_mask_i` is 1. The mask has no effect on pins 0 to 6.
- R7: A pin with no timer role and `dir_i` = 0 has `pin_oe_o` = 0 and `pin_o` = 0.
- R8: Each bit of `cap_o` equals the `pin_i` level sampled two clock edges earlier. A pulse held for three clocks always appears on `cap_o`.
- R9: `pacc_en_o` is 1 exactly when `oc_sel0_i[7]`, `oc_sel1_i[7]` and `oc7_mask_i` are all 0. `pacc_o` equals `cap_o[7]` when `pacc_en_o` is 1, and is 0 otherwise.
- R10: `cnt_rst_o` follows `oc7_cnt_rst_i` in the same cycle in every pin-7 configuration, including while pin 7 feeds the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe for the port data latch |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Per-pin readback (pin level or latch bit) |
| dir_i | input | 8 | Direction per pin, 1 = output |
| oc_sel0_i | input | 8 | Output-compare action-select bit 0 per channel |
| oc_sel1_i | input | 8 | Output-compare action-select bit 1 per channel |
| oc7_mask_i | input | 1 | Channel-7 mask bit that claims pin 7 for output compare 7 |
| oc_pin_lvl_i | input | 8 | Level from the compare unit for each channel |
| oc7_cnt_rst_i | input | 1 | Channel-7 counter-reset request |
| cnt_rst_o | output | 1 | Counter-reset request toward the free-running counter |
| pin_i | input | 8 | Pad input levels |
| pin_o | output | 8 | Pad output levels |
| pin_oe_o | output | 8 | Pad output enables |
| cap_o | output | 8 | Synchronized pin levels for input capture |
| pacc_en_o | output | 1 | Pin 7 is free for the pulse accumulator |
| pacc_o | output | 1 | Gated synchronized pin-7 level for the accumulator |

## Verification
The pin multiplexer is first tried with every pin as an output and then with every pin as an input. This separates the latch path from the live-pin path in both the pad drive and the readback. Long runs with random direction, sparse timer selects, mask and writes then mix all three roles within one cycle. They show whether the timer override wins over the direction bit while the latch keeps being written. Directed steps toggle each channel-7 control alone, to tell the accumulator gating apart from the override. They also set the mask with other pins idle, which shows that the mask touches only pin 7. A held three-clock pulse and a single-clock pulse on an input pin confirm the two-edge synchronizer latency.

// File: rtl/tmr_port_pkg.sv
package tmr_port_pkg;

    typedef enum logic [1:0] {
        ROLE_IN  = 2'd0,
        ROLE_GPO = 2'd1,
        ROLE_TMR = 2'd2
    } pin_role_e;

    // The timer role takes precedence over the direction bit.
    function automatic pin_role_e role_of(input logic dir_bit, input logic tmr_bit);
        if (tmr_bit)      return ROLE_TMR;
        else if (dir_bit) return ROLE_GPO;
        else              return ROLE_IN;
    endfunction

endpackage

// File: rtl/tmr_port_latch.sv
module tmr_port_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] lat_o
);

    typedef struct packed {
        logic [W-1:0] lat;
    } lat_st_t;

    lat_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.lat = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lat_o = st_q.lat;

    // R2
    wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (lat_o == $past(wdata_i)));

endmodule

// File: rtl/tmr_port_sync.sv
module tmr_port_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
        logic                     warm;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.warm   = 1'b1;
        st_d.stg[0] = pin_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.stg[s] = st_q.stg[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stg[STAGES-1];

    // R8
    first_stage_chk: assert property (@(posedge clk) disable iff (!rst_n || !st_q.warm)
        st_q.stg[0] == $past(pin_i));

    for (genvar s = 1; s < STAGES; s++) begin : g_chain_chk
        // R8
        stage_shift_chk: assert property (@(posedge clk) disable iff (!rst_n || !st_q.warm)
            st_q.stg[s] == $past(st_q.stg[s-1]));
    end

endmodule

// File: rtl/tmr_port_drv.sv
module tmr_port_drv
    import tmr_port_pkg::*;
#(
    parameter int W   = 8,
    parameter int ACC = 7
) (
    input  logic [W-1:0] dir_i,
    input  logic [W-1:0] sel0_i,
    input  logic [W-1:0] sel1_i,
    input  logic         mask_acc_i,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] lat_i,
    input  logic [W-1:0] pin_i,
    input  logic         acc_sync_i,
    output logic [W-1:0] pin_o,
    output logic [W-1:0] oe_o,
    output logic [W-1:0] rdata_o,
    output logic         pacc_en_o,
    output logic         pacc_o
);

    pin_role_e role [W];

    for (genvar n = 0; n < W; n++) begin : g_pin
        logic tmr_on;
        if (n == ACC) begin : g_shared
            assign tmr_on = sel0_i[n] | sel1_i[n] | mask_acc_i;
        end else begin : g_plain
            assign tmr_on = sel0_i[n] | sel1_i[n];
        end

        always_comb begin
            role[n] = role_of(dir_i[n], tmr_on);
            unique case (role[n])
                ROLE_TMR: begin
                    oe_o[n]    = 1'b1;
                    pin_o[n]   = lvl_i[n];
                    rdata_o[n] = lat_i[n];
                end
                ROLE_GPO: begin
                    oe_o[n]    = 1'b1;
                    pin_o[n]   = lat_i[n];
                    rdata_o[n] = lat_i[n];
                end
                default: begin
                    oe_o[n]    = 1'b0;
                    pin_o[n]   = 1'b0;
                    rdata_o[n] = pin_i[n];
                end
            endcase
        end
    end

    always_comb begin
        pacc_en_o = ~(sel0_i[ACC] | sel1_i[ACC] | mask_acc_i);
        pacc_o    = pacc_en_o & acc_sync_i;
    end

endmodule

// File: rtl/tmr_port_mux.sv
module tmr_port_mux #(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2,
    parameter int ACC_PIN     = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_wr_i,
    input  logic [W-1:0] bus_wdata_i,
    output logic [W-1:0] bus_rdata_o,
    input  logic [W-1:0] dir_i,
    input  logic [W-1:0] oc_sel0_i,
    input  logic [W-1:0] oc_sel1_i,
    input  logic         oc7_mask_i,
    input  logic [W-1:0] oc_pin_lvl_i,
    input  logic         oc7_cnt_rst_i,
    output logic         cnt_rst_o,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] pin_o,
    output logic [W-1:0] pin_oe_o,
    output logic [W-1:0] cap_o,
    output logic         pacc_en_o,
    output logic         pacc_o
);

    logic [W-1:0] lat_w;
    logic [W-1:0] sync_w;

    tmr_port_latch #(.W(W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr_i),
        .wdata_i (bus_wdata_i),
        .lat_o   (lat_w)
    );

    tmr_port_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .sync_o (sync_w)
    );

    tmr_port_drv #(.W(W), .ACC(ACC_PIN)) u_drv (
        .dir_i      (dir_i),
        .sel0_i     (oc_sel0_i),
        .sel1_i     (oc_sel1_i),
        .mask_acc_i (oc7_mask_i),
        .lvl_i      (oc_pin_lvl_i),
        .lat_i      (lat_w),
        .pin_i      (pin_i),
        .acc_sync_i (sync_w[ACC_PIN]),
        .pin_o      (pin_o),
        .oe_o       (pin_oe_o),
        .rdata_o    (bus_rdata_o),
        .pacc_en_o  (pacc_en_o),
        .pacc_o     (pacc_o)
    );

    assign cap_o     = sync_w;
    assign cnt_rst_o = oc7_cnt_rst_i;

    // R9
    pacc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pacc_en_o |-> (pacc_o == cap_o[ACC_PIN]));

    // R5
    ovr_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oc7_mask_i |-> (pin_oe_o[ACC_PIN] && (pin_o[ACC_PIN] == oc_pin_lvl_i[ACC_PIN])));

    // R2
    rd_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && dir_i[0] && $stable(dir_i)) |=> (bus_rdata_o[0] == $past(bus_wdata_i[0])));

endmodule

// File: tb/tmr_port_mux_tb.sv
`timescale 1ns/1ps
module tmr_port_mux_tb;
    localparam int W = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] dir = '0;
    logic [W-1:0] sel0 = '0;
    logic [W-1:0] sel1 = '0;
    logic         mask7 = 1'b0;
    logic [W-1:0] lvl = '0;
    logic         rst_req = 1'b0;
    logic         cnt_rst;
    logic [W-1:0] pin = '0;
    logic [W-1:0] pin_o, pin_oe, cap;
    logic         pacc_en, pacc;

    tmr_port_mux u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr_i     (bus_wr),
        .bus_wdata_i  (bus_wdata),
        .bus_rdata_o  (bus_rdata),
        .dir_i        (dir),
        .oc_sel0_i    (sel0),
        .oc_sel1_i    (sel1),
        .oc7_mask_i   (mask7),
        .oc_pin_lvl_i (lvl),
        .oc7_cnt_rst_i(rst_req),
        .cnt_rst_o    (cnt_rst),
        .pin_i        (pin),
        .pin_o        (pin_o),
        .pin_oe_o     (pin_oe),
        .cap_o        (cap),
        .pacc_en_o    (pacc_en),
        .pacc_o       (pacc)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model: latch value and a history queue of sampled pins.
    logic [W-1:0] m_lat = '0;
    logic [W-1:0] m_hist[$] = '{8'h00, 8'h00};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lat = '0;
            m_hist.delete();
            m_hist.push_back('0);
            m_hist.push_back('0);
        end else begin
            if (bus_wr) m_lat = bus_wdata;
            m_hist.push_back(pin);
            void'(m_hist.pop_front());
        end
    end

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic [W-1:0] e_oe, e_po, e_rd;
        logic         e_pen;
        for (int i = 0; i < W; i++) begin
            bit t;
            t = sel0[i] | sel1[i] | ((i == 7) ? mask7 : 1'b0);
            e_oe[i] = t | dir[i];
            e_po[i] = t ? lvl[i] : (dir[i] ? m_lat[i] : 1'b0);
            e_rd[i] = (t | dir[i]) ? m_lat[i] : pin[i];
        end
        e_pen = !(sel0[7] | sel1[7] | mask7);
        chk("R2/R3 readback", bus_rdata, e_rd);
        chk("R4/R5/R7 pin level", pin_o, e_po);
        chk("R5/R6/R7 output enable", pin_oe, e_oe);
        chk("R8 capture sync", cap, m_hist[0]);
        chk("R9 accumulator enable", {7'd0, pacc_en}, {7'd0, e_pen});
        chk("R9 accumulator input", {7'd0, pacc}, {7'd0, e_pen & m_hist[0][7]});
        chk("R10 counter reset", {7'd0, cnt_rst}, {7'd0, rst_req});
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #1;
        check_all();
    endtask

    initial begin
        bit seen;
        // R1: reset state
        dir = '1;
        pin = 8'hA5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R1 latch zero in reset", bus_rdata, 8'h00);
        chk("R1 capture zero in reset", cap, 8'h00);
        rst_n = 1'b1;
        tick();
        chk("R1 latch zero after reset", bus_rdata, 8'h00);

        // R2/R4: all outputs, several writes
        for (int k = 0; k < 6; k++) begin
            bus_wr = 1'b1;
            bus_wdata = 8'h3C ^ (8'h11 * k[7:0]);
            tick();
            bus_wr = 1'b0;
            tick();
        end

        // R3/R7: all inputs, live pins
        dir = '0;
        for (int k = 0; k < 20; k++) begin
            pin = 8'($urandom);
            tick();
        end

        // R5: timer override on pin 4 while the latch is written
        dir = '0; sel0 = 8'h10; lvl = 8'h10;
        bus_wr = 1'b1; bus_wdata = 8'h00;
        tick();
        bus_wr = 1'b0;
        chk("R5 override drives level", {7'd0, pin_o[4]}, 8'd1);
        chk("R5 override readback latch", {7'd0, bus_rdata[4]}, 8'd0);
        bus_wr = 1'b1; bus_wdata = 8'h10; lvl = 8'h00;
        tick();
        bus_wr = 1'b0;
        chk("R5 write stored under override", {7'd0, bus_rdata[4]}, 8'd1);
        chk("R5 pin follows timer not latch", {7'd0, pin_o[4]}, 8'd0);
        sel0 = '0;

        // R6: mask claims pin 7 only
        dir = '0; mask7 = 1'b1;
        tick();
        chk("R6 mask enables only pin 7", pin_oe, 8'h80);
        mask7 = 1'b0;

        // R9: each channel-7 control alone drops the gate
        sel0 = 8'h80; tick(); chk("R9 sel0 gates", {7'd0, pacc_en}, 8'd0); sel0 = '0;
        sel1 = 8'h80; tick(); chk("R9 sel1 gates", {7'd0, pacc_en}, 8'd0); sel1 = '0;
        mask7 = 1'b1; tick(); chk("R9 mask gates", {7'd0, pacc_en}, 8'd0); mask7 = 1'b0;
        tick(); chk("R9 all clear enables", {7'd0, pacc_en}, 8'd1);

        // R8: three-clock pulse always seen; single-clock pulse just modelled
        pin = '0; dir = '0;
        repeat (3) tick();
        seen = 0;
        pin[2] = 1'b1;
        repeat (3) begin tick(); if (cap[2]) seen = 1; end
        pin[2] = 1'b0;
        repeat (3) begin tick(); if (cap[2]) seen = 1; end
        chk("R8 three-clock pulse seen", {7'd0, seen}, 8'd1);
        pin[5] = 1'b1; tick(); pin[5] = 1'b0;
        repeat (3) tick();

        // R10: counter reset while pin 7 feeds the accumulator
        pin[7] = 1'b1; rst_req = 1'b1;
        repeat (3) tick();
        chk("R10 reset passes with accumulator on pin 7", {7'd0, cnt_rst}, 8'd1);
        chk("R9 accumulator sees pin 7", {7'd0, pacc}, 8'd1);
        rst_req = 1'b0;

        // Mixed random operation
        for (int k = 0; k < 400; k++) begin
            dir       = 8'($urandom);
            sel0      = 8'($urandom & $urandom & $urandom);
            sel1      = 8'($urandom & $urandom & $urandom);
            mask7     = 1'($urandom % 4 == 0);
            lvl       = 8'($urandom);
            pin       = 8'($urandom);
            bus_wr    = 1'($urandom);
            bus_wdata = 8'($urandom);
            rst_req   = 1'($urandom);
            tick();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule